// File: doc/BRIEF.md
# RC5-32/12 Iterative Cipher Core

This block encrypts or decrypts one 64-bit block at a time with the RC5 cipher, using 32-bit words, twelve rounds and a 128-bit user key. The block is held as two words, A and B. Each round is folded over two clocks. Encryption updates A on the first clock and B on the second. Decryption updates B first and A second. Every rotation distance comes from the low five bits of the data word that controls it.

The core builds its own 26-word subkey table. It first fills the table from two fixed constants, then runs a registered mixing loop of 78 steps that folds the user key into the table. The core remembers the key it last expanded. When a start arrives with a different key, or when no key has been expanded since reset, expansion runs first and the data operation follows without further input. A start that arrives while an operation is in progress is dropped. The result is flagged by a single-cycle done pulse and stays on the output until the next accepted start.

Top module: `rc5_core`

## Requirements
- R1: A synchronous, active-high reset clears dout to zero and done to low, and forgets the expanded key. The next start therefore always runs key expansion (latency 129).
- R2: Encryption loads A from din[31:0] and B from din[63:32], then adds S[0] to A and S[1] to B. For each round i from 1 to 12 it sets A = rotl(A xor B, B[4:0]) + S[2i], then B = rotl(B xor A, A[4:0]) + S[2i+1]. The output is dout = {B, A}.
- R3: With decrypt high at start, the core runs i from 12 down to 1, setting B = rotr(B − S[2i+1], A[4:0]) xor A and then A = rotr(A − S[2i], B[4:0]) xor B. It then subtracts S[1] from B and S[0] from A, so that decryption undoes encryption under the same key.
- R4: Expansion fills S[k] = 0xB7E15163 + k·0x9E3779B9 (mod 2^32) for k = 0 to 25. L[j] = key[32j+31:32j] for j = 0 to 3. It then runs 78 steps with accumulators X and Y starting at 0: S[i] = rotl(S[i]+X+Y, 3), X = S[i], L[j] = rotl(L[j]+X+Y, (X+Y)[4:0]), Y = L[j], with i stepping mod 26 and j stepping mod 4. An all-zero key and an all-zero block encrypt to 0x6D8F4B15_EEDBA521.
- R5: When the key matches the one already expanded, done goes high 25 cycles after the cycle in which start is sampled, for both directions.
- R6: When the key differs from the expanded one, 26 fill cycles and 78 mix cycles run before any data update, and done goes high 129 cycles after start is sampled.
- R7: A start that arrives while the core is busy has no effect. The running result and its latency are unchanged, and no extra done pulse follows.
- R8: done is high for exactly one cycle. dout holds the result while the core is idle and no start is given.
- R9: decrypt, key and din are sampled only in the cycle a start is accepted. Changing them while busy does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; accepted only when idle |
| decrypt | input | 1 | 1 selects decryption, 0 encryption; sampled with start |
| key | input | 128 | User key; word j is bits 32j+31 down to 32j |
| din | input | 64 | Input block: A in bits 31:0, B in bits 63:32 |
| dout | output | 64 | Result block, same layout as din |
| done | output | 1 | One-cycle pulse when dout holds a new result |

## Verification
The assertions assume that start is always a clean, synchronous level. They also assume that the key and the direction select, as seen by the block, only matter in the cycle start is accepted, so holding them or changing them mid-operation must leave every property true. The stimulus drives every input on the falling edge. Starts given while the core is busy, and key or direction changes while it is busy, come only from the directed tests, which deliberately stress the rule that busy-time inputs are ignored. The vector walk applies its inputs only while the core is idle.

// File: rtl/rc5_pkg.sv
package rc5_pkg;

  typedef logic [31:0] word_t;

  // Fill constants for the 32-bit word size
  localparam word_t FILL_BASE = 32'hB7E15163;
  localparam word_t FILL_STEP = 32'h9E3779B9;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_WHITEN,
    OP_ENC_A,
    OP_ENC_B,
    OP_DEC_B,
    OP_DEC_A,
    OP_UNWHITEN
  } dp_op_e;

  function automatic word_t rotl32(input word_t x, input logic [4:0] sh);
    logic [63:0] twice;
    twice = {x, x} << sh;
    return twice[63:32];
  endfunction

  function automatic word_t rotr32(input word_t x, input logic [4:0] sh);
    logic [63:0] twice;
    twice = {x, x} >> sh;
    return twice[31:0];
  endfunction

  // Left half of an encryption round
  function automatic word_t enc_a_step(input word_t a, input word_t b, input word_t s);
    return rotl32(a ^ b, b[4:0]) + s;
  endfunction

  // Right half of an encryption round
  function automatic word_t enc_b_step(input word_t b, input word_t a, input word_t s);
    return rotl32(b ^ a, a[4:0]) + s;
  endfunction

  function automatic word_t dec_b_step(input word_t b, input word_t a, input word_t s);
    return rotr32(b - s, a[4:0]) ^ a;
  endfunction

  function automatic word_t dec_a_step(input word_t a, input word_t b, input word_t s);
    return rotr32(a - s, b[4:0]) ^ b;
  endfunction

  // Key mixing: new table word
  function automatic word_t mix_table(input word_t s, input word_t x, input word_t y);
    return rotl32(s + x + y, 5'd3);
  endfunction

  // Key mixing: new key word, x is the freshly mixed table word
  function automatic word_t mix_key(input word_t l, input word_t x, input word_t y);
    word_t amt;
    amt = x + y;
    return rotl32(l + amt, amt[4:0]);
  endfunction

endpackage

// File: rtl/rc5_key_sched.sv
module rc5_key_sched
  import rc5_pkg::*;
#(
  parameter int ROUNDS   = 12,
  parameter int KEY_BITS = 128,
  localparam int T_WORDS = 2 * (ROUNDS + 1),
  localparam int IW      = $clog2(T_WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [KEY_BITS-1:0] key,
  input  logic [IW-1:0]       rd_idx0,
  input  logic [IW-1:0]       rd_idx1,
  output word_t               rd_word0,
  output word_t               rd_word1,
  output logic                key_match,
  output logic                table_ok,
  output logic                busy,
  output logic                fin
);

  localparam int C_WORDS = KEY_BITS / 32;
  localparam int BIGGER  = (T_WORDS > C_WORDS) ? T_WORDS : C_WORDS;
  localparam int STEPS   = 3 * BIGGER;
  localparam int JW      = (C_WORDS > 1) ? $clog2(C_WORDS) : 1;
  localparam int CW      = $clog2(STEPS + 1);

  typedef enum logic [1:0] {KS_IDLE, KS_FILL, KS_MIX} ks_phase_e;

  ks_phase_e           phase;
  word_t               s_tab [T_WORDS];
  word_t               l_tab [C_WORDS];
  logic [KEY_BITS-1:0] key_seen;
  logic                ok_q;
  word_t               fill_val;
  logic [CW-1:0]       step_cnt;
  logic [IW-1:0]       i_idx;
  logic [JW-1:0]       j_idx;
  word_t               acc_x, acc_y;
  word_t               mix_x_nxt, mix_y_nxt;
  logic                i_last, j_last;

  always_comb begin
    mix_x_nxt = mix_table(s_tab[i_idx], acc_x, acc_y);
    mix_y_nxt = mix_key(l_tab[j_idx], mix_x_nxt, acc_y);
  end

  assign i_last    = (i_idx == IW'(T_WORDS - 1));
  assign j_last    = (j_idx == JW'(C_WORDS - 1));
  assign fin       = (phase == KS_MIX) && (step_cnt == CW'(STEPS - 1));
  assign busy      = (phase != KS_IDLE);
  assign table_ok  = ok_q;
  assign key_match = ok_q && (key == key_seen);
  assign rd_word0  = s_tab[rd_idx0];
  assign rd_word1  = s_tab[rd_idx1];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= KS_IDLE;
      ok_q     <= 1'b0;
      key_seen <= '0;
      fill_val <= FILL_BASE;
      step_cnt <= '0;
      i_idx    <= '0;
      j_idx    <= '0;
      acc_x    <= '0;
      acc_y    <= '0;
      for (int k = 0; k < T_WORDS; k++) s_tab[k] <= '0;
      for (int k = 0; k < C_WORDS; k++) l_tab[k] <= '0;
    end else begin
      case (phase)
        KS_IDLE: begin
          if (go) begin
            phase    <= KS_FILL;
            ok_q     <= 1'b0;
            key_seen <= key;
            fill_val <= FILL_BASE;
            step_cnt <= '0;
            i_idx    <= '0;
            j_idx    <= '0;
            acc_x    <= '0;
            acc_y    <= '0;
            for (int k = 0; k < C_WORDS; k++) l_tab[k] <= key[32*k +: 32];
          end
        end
        KS_FILL: begin
          s_tab[i_idx] <= fill_val;
          fill_val     <= fill_val + FILL_STEP;
          if (i_last) begin
            i_idx <= '0;
            phase <= KS_MIX;
          end else begin
            i_idx <= i_idx + 1'b1;
          end
        end
        KS_MIX: begin
          s_tab[i_idx] <= mix_x_nxt;
          l_tab[j_idx] <= mix_y_nxt;
          acc_x        <= mix_x_nxt;
          acc_y        <= mix_y_nxt;
          i_idx        <= i_last ? '0 : i_idx + 1'b1;
          j_idx        <= j_last ? '0 : j_idx + 1'b1;
          step_cnt     <= step_cnt + 1'b1;
          if (fin) begin
            phase <= KS_IDLE;
            ok_q  <= 1'b1;
          end
        end
        default: phase <= KS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rc5_round_unit.sv
module rc5_round_unit
  import rc5_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dp_op_e      op,
  input  logic [63:0] din,
  input  word_t       s_even,
  input  word_t       s_odd,
  output word_t       half_a,
  output word_t       half_b
);

  word_t a_q, b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      case (op)
        OP_LOAD: begin
          a_q <= din[31:0];
          b_q <= din[63:32];
        end
        OP_WHITEN: begin
          a_q <= a_q + s_even;
          b_q <= b_q + s_odd;
        end
        OP_ENC_A:    a_q <= enc_a_step(a_q, b_q, s_even);
        OP_ENC_B:    b_q <= enc_b_step(b_q, a_q, s_odd);
        OP_DEC_B:    b_q <= dec_b_step(b_q, a_q, s_odd);
        OP_DEC_A:    a_q <= dec_a_step(a_q, b_q, s_even);
        OP_UNWHITEN: begin
          a_q <= a_q - s_even;
          b_q <= b_q - s_odd;
        end
        default: ;
      endcase
    end
  end

  assign half_a = a_q;
  assign half_b = b_q;

endmodule

// File: rtl/rc5_ctrl.sv
module rc5_ctrl
  import rc5_pkg::*;
#(
  parameter int ROUNDS = 12,
  localparam int RW    = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          decrypt,
  input  logic          key_match,
  input  logic          ks_fin,
  output logic          ks_go,
  output dp_op_e        op,
  output logic [RW-1:0] rnd,
  output logic          busy,
  output logic          done
);

  typedef enum logic [2:0] {C_IDLE, C_KEYS, C_WHITEN, C_ROUND, C_UNWHITEN, C_FIN} ctl_state_e;

  ctl_state_e    state;
  logic [RW-1:0] rnd_q;
  logic          half_q;
  logic          dec_q;
  logic          accept;

  assign accept = (state == C_IDLE) && start;
  assign ks_go  = accept && !key_match;
  assign busy   = (state != C_IDLE);
  assign done   = (state == C_FIN);
  assign rnd    = rnd_q;

  always_comb begin
    op = OP_HOLD;
    case (state)
      C_IDLE:     if (start) op = OP_LOAD;
      C_WHITEN:   op = OP_WHITEN;
      C_ROUND: begin
        if (!dec_q) op = half_q ? OP_ENC_B : OP_ENC_A;
        else        op = half_q ? OP_DEC_A : OP_DEC_B;
      end
      C_UNWHITEN: op = OP_UNWHITEN;
      default:    op = OP_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= C_IDLE;
      rnd_q  <= '0;
      half_q <= 1'b0;
      dec_q  <= 1'b0;
    end else begin
      case (state)
        C_IDLE: begin
          if (start) begin
            dec_q  <= decrypt;
            half_q <= 1'b0;
            rnd_q  <= decrypt ? RW'(ROUNDS) : '0;
            if (!key_match)   state <= C_KEYS;
            else if (decrypt) state <= C_ROUND;
            else              state <= C_WHITEN;
          end
        end
        C_KEYS: begin
          if (ks_fin) state <= dec_q ? C_ROUND : C_WHITEN;
        end
        C_WHITEN: begin
          rnd_q <= RW'(1);
          state <= C_ROUND;
        end
        C_ROUND: begin
          half_q <= ~half_q;
          if (half_q) begin
            if (!dec_q) begin
              if (rnd_q == RW'(ROUNDS)) state <= C_FIN;
              else                      rnd_q <= rnd_q + 1'b1;
            end else begin
              if (rnd_q == RW'(1)) begin
                rnd_q <= '0;
                state <= C_UNWHITEN;
              end else begin
                rnd_q <= rnd_q - 1'b1;
              end
            end
          end
        end
        C_UNWHITEN: state <= C_FIN;
        C_FIN:      state <= C_IDLE;
        default:    state <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rc5_core.sv
module rc5_core
  import rc5_pkg::*;
#(
  parameter int ROUNDS   = 12,
  parameter int KEY_BITS = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                decrypt,
  input  logic [KEY_BITS-1:0] key,
  input  logic [63:0]         din,
  output logic [63:0]         dout,
  output logic                done
);

  localparam int T_WORDS = 2 * (ROUNDS + 1);
  localparam int IW      = $clog2(T_WORDS);
  localparam int RW      = $clog2(ROUNDS + 1);

  // Named internal events, visible to the checker
  logic          ks_go_w;
  logic          ks_fin_w;
  logic          ks_busy_w;
  logic          key_match_w;
  logic          table_ok_w;
  logic          busy_w;
  logic [RW-1:0] rnd_w;
  dp_op_e        op_w;
  logic [IW-1:0] idx_even_w, idx_odd_w;
  word_t         s_even_w, s_odd_w;
  word_t         half_a_w, half_b_w;

  assign idx_even_w = IW'({rnd_w, 1'b0});
  assign idx_odd_w  = IW'({rnd_w, 1'b1});

  rc5_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .decrypt   (decrypt),
    .key_match (key_match_w),
    .ks_fin    (ks_fin_w),
    .ks_go     (ks_go_w),
    .op        (op_w),
    .rnd       (rnd_w),
    .busy      (busy_w),
    .done      (done)
  );

  rc5_key_sched #(.ROUNDS(ROUNDS), .KEY_BITS(KEY_BITS)) u_keys (
    .clk       (clk),
    .rst       (rst),
    .go        (ks_go_w),
    .key       (key),
    .rd_idx0   (idx_even_w),
    .rd_idx1   (idx_odd_w),
    .rd_word0  (s_even_w),
    .rd_word1  (s_odd_w),
    .key_match (key_match_w),
    .table_ok  (table_ok_w),
    .busy      (ks_busy_w),
    .fin       (ks_fin_w)
  );

  rc5_round_unit u_dp (
    .clk    (clk),
    .rst    (rst),
    .op     (op_w),
    .din    (din),
    .s_even (s_even_w),
    .s_odd  (s_odd_w),
    .half_a (half_a_w),
    .half_b (half_b_w)
  );

  assign dout = {half_b_w, half_a_w};

endmodule

// File: rtl/rc5_core_chk.sv
module rc5_core_chk
  import rc5_pkg::*;
#(
  parameter int ROUNDS = 12,
  localparam int RW    = $clog2(ROUNDS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [63:0]   dout,
  input logic          done,
  input logic          busy_w,
  input logic          ks_go_w,
  input logic          ks_busy_w,
  input logic          table_ok_w,
  input logic [RW-1:0] rnd_w,
  input dp_op_e        op_w
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_w && !start) |=> $stable(dout));

  // R6
  keys_first_chk: assert property (@(posedge clk) disable iff (rst)
    ks_busy_w |-> (op_w == OP_HOLD));

  // R6
  done_table_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> table_ok_w);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_w && start) |-> !ks_go_w);

  // R5
  round_range_chk: assert property (@(posedge clk) disable iff (rst)
    rnd_w <= RW'(ROUNDS));

endmodule

bind rc5_core rc5_core_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .dout       (dout),
  .done       (done),
  .busy_w     (busy_w),
  .ks_go_w    (ks_go_w),
  .ks_busy_w  (ks_busy_w),
  .table_ok_w (table_ok_w),
  .rnd_w      (rnd_w),
  .op_w       (op_w)
);

// File: tb/tb_rc5_core.sv
`timescale 1ns/1ps
module tb_rc5_core;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic         decrypt;
  logic [127:0] key;
  logic [63:0]  din;
  logic [63:0]  dout;
  logic         done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rc5_core dut (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt),
    .key(key), .din(din), .dout(dout), .done(done)
  );

  // ---------------- reference model ----------------
  logic [31:0] msk [0:25];
  logic [31:0] mlk [0:3];

  function automatic logic [31:0] rl(input logic [31:0] v, input logic [31:0] n);
    logic [4:0] k;
    k = n[4:0];
    if (k == 0) return v;
    return (v << k) | (v >> (32 - k));
  endfunction

  function automatic logic [31:0] rr(input logic [31:0] v, input logic [31:0] n);
    logic [4:0] k;
    k = n[4:0];
    if (k == 0) return v;
    return (v >> k) | (v << (32 - k));
  endfunction

  function automatic logic [63:0] model(input logic [127:0] k, input logic [63:0] x, input logic dec);
    logic [31:0] a, b;
    int i, j;
    for (int t = 0; t < 26; t++) msk[t] = 32'hB7E15163 + 32'(t) * 32'h9E3779B9;
    for (int t = 0; t < 4; t++)  mlk[t] = k[32*t +: 32];
    a = 0; b = 0; i = 0; j = 0;
    for (int n = 0; n < 78; n++) begin
      a = rl(msk[i] + a + b, 3);
      msk[i] = a;
      b = rl(mlk[j] + a + b, a + b);
      mlk[j] = b;
      i = (i + 1) % 26;
      j = (j + 1) % 4;
    end
    a = x[31:0];
    b = x[63:32];
    if (!dec) begin
      a = a + msk[0];
      b = b + msk[1];
      for (int r = 1; r <= 12; r++) begin
        a = rl(a ^ b, b) + msk[2*r];
        b = rl(b ^ a, a) + msk[2*r+1];
      end
    end else begin
      for (int r = 12; r >= 1; r--) begin
        b = rr(b - msk[2*r+1], a) ^ a;
        a = rr(a - msk[2*r], b) ^ b;
      end
      b = b - msk[1];
      a = a - msk[0];
    end
    return {b, a};
  endfunction

  // ---------------- vectors ----------------
  localparam logic [127:0] K_A = 128'h0;
  localparam logic [127:0] K_B = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
  localparam logic [127:0] K_C = {128{1'b1}};

  localparam int NV = 6;
  localparam logic [127:0] VK [NV] = '{K_A, K_A, K_A, K_B, K_B, K_C};
  localparam logic [63:0]  VD [NV] = '{64'h0, 64'h01234567_89ABCDEF, 64'hFFFFFFFF_00000000,
                                       64'h11223344_55667788, 64'hDEADBEEF_CAFEF00D, {64{1'b1}}};
  localparam logic         VM [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int           VL [NV] = '{129, 25, 25, 129, 25, 129};

  // ---------------- helpers ----------------
  logic [63:0] res;
  int          cyc;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] k, input logic [63:0] x, input logic dec);
    @(negedge clk);
    key = k; din = x; decrypt = dec; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 400);
    res = dout;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] ct, want;
    int pulses;
    rst = 1'b1; start = 1'b0; decrypt = 1'b0; key = '0; din = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dout after reset", dout, 64'h0);
    chk("R1 done after reset", {63'h0, done}, 64'h0);

    // Vector walk: R2 R3 R5 R6
    for (int v = 0; v < NV; v++) begin
      want = model(VK[v], VD[v], VM[v]);
      run_op(VK[v], VD[v], VM[v]);
      chk(VM[v] ? "R3 decrypt result" : "R2 encrypt result", res, want);
      chk(VL[v] == 129 ? "R6 latency new key" : "R5 latency cached key", 64'(cyc), 64'(VL[v]));
    end

    // R4 fixed vector with zero key
    run_op(K_A, 64'h0, 1'b0);
    chk("R4 zero key vector", res, 64'h6D8F4B15_EEDBA521);

    // R3 round trip
    run_op(K_B, 64'hA5A5A5A5_5A5A5A5A, 1'b0);
    ct = res;
    run_op(K_B, ct, 1'b1);
    chk("R3 round trip", res, 64'hA5A5A5A5_5A5A5A5A);

    // R8 done width and hold
    @(negedge clk);
    chk("R8 done low after pulse", {63'h0, done}, 64'h0);
    repeat (3) @(negedge clk);
    chk("R8 dout held while idle", dout, 64'hA5A5A5A5_5A5A5A5A);

    // R7 start while busy is dropped
    want = model(K_B, 64'h0BADF00D_12345678, 1'b0);
    @(negedge clk);
    key = K_B; din = 64'h0BADF00D_12345678; decrypt = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 5) begin start = 1'b1; din = 64'h99999999_88888888; end
      if (cyc == 6) start = 1'b0;
    end while (!done && cyc < 400);
    chk("R7 result with busy start", dout, want);
    chk("R7 latency with busy start", 64'(cyc), 64'd25);
    pulses = 0;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk("R7 no extra done", 64'(pulses), 64'd0);

    // R9 inputs changed while busy
    want = model(K_B, 64'h13579BDF_2468ACE0, 1'b0);
    @(negedge clk);
    key = K_B; din = 64'h13579BDF_2468ACE0; decrypt = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 2) begin decrypt = 1'b1; key = K_C; din = 64'h0; end
    end while (!done && cyc < 400);
    chk("R9 result with changed inputs", dout, want);
    chk("R9 latency with changed inputs", 64'(cyc), 64'd25);

    // R1 reset mid-operation
    @(negedge clk);
    key = K_B; din = 64'h1; decrypt = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 dout after mid-op reset", dout, 64'h0);
    chk("R1 done after mid-op reset", {63'h0, done}, 64'h0);
    want = model(K_B, 64'h2, 1'b1);
    run_op(K_B, 64'h2, 1'b1);
    chk("R1 key forgotten latency", 64'(cyc), 64'd129);
    chk("R3 decrypt after reset", res, want);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule